// File: doc/BRIEF.md
# Chip Phase Stepper with Tau-Dither

This block produces the receive chip strobe of a spread-spectrum receiver. A free-running counter divides the master clock by sixteen, so one chip lasts sixteen master clocks and one sixteenth of a chip equals one clock. A tracking loop outside the block moves the strobe phase in sixteenth-chip steps. Each accepted update request moves the phase by a programmed step count. A direction input picks whether the phase moves earlier (advance) or later (retard). Update requests closer together than the minimum spacing are dropped.

On top of the commanded phase, a tau-dither function swaps between two states on every TDD cycle boundary. One state leaves the phase alone and the other retards it by a programmed amplitude. The tracking loop compares signal strength in the two states to find the correlation peak. The dither amplitude is held in a shadow register and only moves to the active copy when the receive code is reloaded. The current dither state is shown on an output. Every phase change becomes a one-time change in the length of a chip period, and the total phase is preserved.

Top module: `chip_phase_dither`

## Requirements
- R1: While reset is held, `chip_stb_o` and `dither_o` are low. After reset is released, the first strobe is high after the 16th rising edge with reset low.
- R2: With no update, dither change or reload, `chip_stb_o` is a one-clock pulse every 16 clocks.
- R3: An accepted update moves the phase by `step_sel_i` + 1 master clocks. The value 0 gives a step of 1 and the value 7 gives a step of 8.
- R4: An accepted update with `adv_i` high (advance) shortens the chip period in progress by the step count. A request sampled on the first edge after a strobe gives a strobe interval of 16 − step.
- R5: An accepted update with `adv_i` low (retard) lengthens the chip period in progress by the step count, giving an interval of 16 + step.
- R6: An update request sampled fewer than 32 clocks after the last accepted one is ignored and does not move the phase. A request exactly 32 clocks after it is accepted.
- R7: While `track_i` is low, the dither state is forced to unretarded on the next clock. Any retard still applied is removed as a shortening equal to the active amplitude. `tdd_tick_i` is ignored.
- R8: While `track_i` is high, each `tdd_tick_i` pulse toggles the dither state. Entering the retarded state lengthens the current chip period by the active amplitude, and leaving it shortens the period by the same amount.
- R9: A new `dither_amp_i` value has no effect until a `reload_i` pulse. If the dither is retarded at the reload, the applied retard changes at once by the new amplitude minus the old one. The active amplitude is 0 after reset.
- R10: `dither_o` is high exactly while the retarded dither state is applied, from the clock after the tick that enters it.
- R11: An advance larger than what remains of the current period fires the strobe on the next clock. The remaining advance is taken from the following period, so the total phase shift is still the full step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Phase step request, sampled each clock |
| adv_i | input | 1 | Step direction: 1 = advance, 0 = retard |
| step_sel_i | input | 3 | Step size minus one, in sixteenths of a chip |
| track_i | input | 1 | Dither enable |
| dither_amp_i | input | 4 | Dither amplitude in sixteenths of a chip (shadow value) |
| tdd_tick_i | input | 1 | One-clock pulse at each TDD cycle boundary |
| reload_i | input | 1 | Receive code reload pulse; copies the amplitude into the active register |
| chip_stb_o | output | 1 | Receive chip strobe, one clock wide |
| dither_o | output | 1 | High while the retarded dither state is applied |

## Verification
Each stimulus is placed on the falling edge right after a strobe, so it is sampled on the first rising edge of a new chip period. A step or dither change of n clocks then shows up as a strobe interval of 16 ± n, counted in rising edges up to the next strobe. `dither_o` is checked one clock after the tick, reload or track change that drives it. The case where an advance spills into the next period is checked across two intervals (14 and then 10). The 31- and 32-clock update spacing is checked by the total of two intervals. That total is 32 when the request is dropped and 34 when it is taken.

// File: rtl/cps_pkg.sv
package cps_pkg;

    // Width of a signed phase offset, in master clocks
    localparam int OFS_W = 8;

    typedef logic signed [OFS_W-1:0] ofs_t;

    typedef enum logic {
        DIR_RETARD  = 1'b0,
        DIR_ADVANCE = 1'b1
    } step_dir_e;

    typedef enum logic {
        DTH_PLAIN    = 1'b0,
        DTH_RETARDED = 1'b1
    } dith_state_e;

    // One phase adjustment: positive delta = retard (later), negative = advance
    typedef struct packed {
        logic valid;
        ofs_t delta;
    } phase_adj_t;

    // The step select field encodes size minus one
    function automatic int unsigned step_count(input int unsigned sel);
        return sel + 1;
    endfunction

    function automatic ofs_t signed_mag(input int unsigned mag, input step_dir_e dir);
        ofs_t m;
        m = ofs_t'(mag);
        return (dir == DIR_ADVANCE) ? -m : m;
    endfunction

endpackage

// File: rtl/cps_update_gate.sv
module cps_update_gate
    import cps_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int GAP    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] step_sel_i,
    output phase_adj_t        adj_o
);

    localparam int GW = $clog2(GAP);

    logic [GW-1:0] hold_q;
    logic          take;

    // A request is taken only once the spacing window has run out
    assign take = upd_i && (hold_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= GW'(GAP - 1);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - GW'(1);
        end
    end

    always_comb begin
        adj_o.valid = take;
        adj_o.delta = '0;
        if (take) begin
            adj_o.delta = signed_mag(step_count(32'(step_sel_i)), step_dir_e'(adv_i));
        end
    end

endmodule

// File: rtl/cps_dither.sv
module cps_dither
    import cps_pkg::*;
#(
    parameter int AMP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             track_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [AMP_W-1:0] amp_i,
    output phase_adj_t       adj_o,
    output logic             retarded_o
);

    dith_state_e      st_q, st_d;
    logic [AMP_W-1:0] amp_q, amp_d;
    logic [AMP_W-1:0] applied_q, applied_d;

    always_comb begin
        amp_d = reload_i ? amp_i : amp_q;

        if (!track_i) begin
            st_d = DTH_PLAIN;
        end else if (tick_i) begin
            st_d = (st_q == DTH_RETARDED) ? DTH_PLAIN : DTH_RETARDED;
        end else begin
            st_d = st_q;
        end

        applied_d = (st_d == DTH_RETARDED) ? amp_d : '0;

        // The phase core only sees the change in applied retard
        adj_o.valid = (applied_d != applied_q);
        adj_o.delta = ofs_t'($signed({1'b0, applied_d})) - ofs_t'($signed({1'b0, applied_q}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= DTH_PLAIN;
            amp_q     <= '0;
            applied_q <= '0;
        end else begin
            st_q      <= st_d;
            amp_q     <= amp_d;
            applied_q <= applied_d;
        end
    end

    assign retarded_o = (st_q == DTH_RETARDED);

endmodule

// File: rtl/cps_phase_core.sv
module cps_phase_core
    import cps_pkg::*;
#(
    parameter int SUB_W = 4,
    parameter int N_ADJ = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  phase_adj_t adj_i [N_ADJ],
    output logic       stb_o
);

    localparam int CHIP_LEN = 1 << SUB_W;
    localparam int TERM     = CHIP_LEN - 1;
    localparam int WW       = OFS_W + 2;
    localparam int CNT_W    = OFS_W;

    typedef logic signed [WW-1:0] wide_t;

    logic [CNT_W-1:0] cnt_q;
    ofs_t             pend_q;
    wide_t            adj_sum;
    wide_t            cnt_w;
    wide_t            limit_w;
    wide_t            pend_nx;
    logic             fire;

    always_comb begin
        adj_sum = '0;
        for (int i = 0; i < N_ADJ; i++) begin
            if (adj_i[i].valid) begin
                adj_sum = adj_sum + wide_t'(adj_i[i].delta);
            end
        end
    end

    // The period in progress ends when the count reaches the nominal
    // terminal plus the pending offset. Whatever part of the offset the
    // period could not absorb is carried on to the next period.
    always_comb begin
        cnt_w   = $signed({2'b00, cnt_q});
        limit_w = wide_t'(TERM) + wide_t'(pend_q);
        fire    = (cnt_w >= limit_w);
        if (fire) begin
            pend_nx = wide_t'(pend_q) + wide_t'(TERM) - cnt_w + adj_sum;
        end else begin
            pend_nx = wide_t'(pend_q) + adj_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= '0;
            stb_o  <= 1'b0;
        end else begin
            stb_o  <= fire;
            cnt_q  <= fire ? '0 : cnt_q + CNT_W'(1);
            pend_q <= ofs_t'(pend_nx);
        end
    end

endmodule

// File: rtl/chip_phase_dither.sv
module chip_phase_dither
    import cps_pkg::*;
#(
    parameter int SUB_W   = 4,
    parameter int STEP_W  = 3,
    parameter int AMP_W   = 4,
    parameter int UPD_GAP = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] step_sel_i,
    input  logic              track_i,
    input  logic [AMP_W-1:0]  dither_amp_i,
    input  logic              tdd_tick_i,
    input  logic              reload_i,
    output logic              chip_stb_o,
    output logic              dither_o
);

    localparam int N_ADJ = 2;

    phase_adj_t adj_bus [N_ADJ];

    cps_update_gate #(
        .STEP_W (STEP_W),
        .GAP    (UPD_GAP)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .upd_i      (upd_i),
        .adv_i      (adv_i),
        .step_sel_i (step_sel_i),
        .adj_o      (adj_bus[0])
    );

    cps_dither #(
        .AMP_W (AMP_W)
    ) u_dither (
        .clk        (clk),
        .rst        (rst),
        .track_i    (track_i),
        .tick_i     (tdd_tick_i),
        .reload_i   (reload_i),
        .amp_i      (dither_amp_i),
        .adj_o      (adj_bus[1]),
        .retarded_o (dither_o)
    );

    cps_phase_core #(
        .SUB_W (SUB_W),
        .N_ADJ (N_ADJ)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .adj_i (adj_bus),
        .stb_o (chip_stb_o)
    );

endmodule

// File: rtl/chip_phase_dither_chk.sv
module chip_phase_dither_chk (
    input logic clk,
    input logic rst,
    input logic upd_i,
    input logic track_i,
    input logic tdd_tick_i,
    input logic reload_i,
    input logic chip_stb_o,
    input logic dither_o
);

    logic [7:0] quiet_q;
    logic [7:0] since_q;
    logic       seen_q;
    logic       track_q;
    logic       activity;

    assign activity = upd_i || reload_i || (track_i && tdd_tick_i) || (track_i != track_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
            since_q <= '0;
            seen_q  <= 1'b0;
            track_q <= 1'b0;
        end else begin
            track_q <= track_i;
            quiet_q <= activity ? 8'd0 : ((quiet_q == 8'hFF) ? quiet_q : quiet_q + 8'd1);
            if (chip_stb_o) begin
                since_q <= 8'd1;
                seen_q  <= 1'b1;
            end else if (since_q != 8'hFF) begin
                since_q <= since_q + 8'd1;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!chip_stb_o && !dither_o));

    // R2
    nominal_period_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_stb_o && seen_q && quiet_q >= 8'd100) |-> (since_q == 8'd16));

    // R7
    track_off_chk: assert property (@(posedge clk) disable iff (rst)
        !track_i |=> !dither_o);

    // R8
    tick_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (track_i && tdd_tick_i) |=> (dither_o != $past(dither_o)));

    // R10
    dither_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (track_i && !tdd_tick_i) |=> $stable(dither_o));

endmodule

bind chip_phase_dither chip_phase_dither_chk u_chk (.*);

// File: tb/chip_phase_dither_tb.sv
module chip_phase_dither_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_i = 1'b0;
    logic       adv_i = 1'b0;
    logic [2:0] step_sel_i = '0;
    logic       track_i = 1'b0;
    logic [3:0] dither_amp_i = '0;
    logic       tdd_tick_i = 1'b0;
    logic       reload_i = 1'b0;
    logic       chip_stb_o;
    logic       dither_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    chip_phase_dither u_dut (
        .clk          (clk),
        .rst          (rst),
        .upd_i        (upd_i),
        .adv_i        (adv_i),
        .step_sel_i   (step_sel_i),
        .track_i      (track_i),
        .dither_amp_i (dither_amp_i),
        .tdd_tick_i   (tdd_tick_i),
        .reload_i     (reload_i),
        .chip_stb_o   (chip_stb_o),
        .dither_o     (dither_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (!chip_stb_o) @(negedge clk);
    endtask

    // Starting at a strobe, pulse the chosen commands after w falling edges,
    // then count clocks until nint more strobes have been seen.
    task automatic span(input int w, input bit u, input bit a, input logic [2:0] sel,
                        input bit tk, input bit rl, input int nint, output int g);
        int s;
        g = 0;
        s = 0;
        adv_i      = a;
        step_sel_i = sel;
        if (w == 0) begin
            upd_i = u; tdd_tick_i = tk; reload_i = rl;
        end
        while (s < nint) begin
            @(negedge clk);
            g++;
            if (chip_stb_o) s++;
            if (g == w) begin
                upd_i = u; tdd_tick_i = tk; reload_i = rl;
            end else begin
                upd_i = 1'b0; tdd_tick_i = 1'b0; reload_i = 1'b0;
            end
        end
        upd_i = 1'b0; tdd_tick_i = 1'b0; reload_i = 1'b0;
    endtask

    task automatic settle();
        int g;
        span(1000, 0, 0, 3'd0, 0, 0, 2, g);
        check("R2 two idle chips", g, 32);
    endtask

    task automatic t_reset();
        int g;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 strobe in reset", int'(chip_stb_o), 0);
        check("R1 dither in reset", int'(dither_o), 0);
        rst = 1'b0;
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!chip_stb_o && g < 100);
        check("R1 first strobe", g, 16);
    endtask

    task automatic t_nominal();
        int g;
        span(1000, 0, 0, 3'd0, 0, 0, 3, g);
        check("R2 three idle chips", g, 48);
    endtask

    task automatic t_advance();
        int g;
        settle();
        span(0, 1, 1, 3'd3, 0, 0, 1, g);
        check("R4 advance 4", g, 12);
        settle();
        span(0, 1, 1, 3'd7, 0, 0, 1, g);
        check("R3 R4 advance max step 8", g, 8);
    endtask

    task automatic t_retard();
        int g;
        settle();
        span(0, 1, 0, 3'd0, 0, 0, 1, g);
        check("R3 R5 retard min step 1", g, 17);
        settle();
        span(0, 1, 0, 3'd5, 0, 0, 1, g);
        check("R5 retard 6", g, 22);
    endtask

    task automatic t_carry();
        int g;
        settle();
        span(12, 1, 1, 3'd7, 0, 0, 1, g);
        check("R11 late advance fires next clock", g, 14);
        span(1000, 0, 0, 3'd0, 0, 0, 1, g);
        check("R11 remainder taken from next chip", g, 10);
    endtask

    task automatic t_guard();
        int g;
        settle();
        span(0, 1, 0, 3'd1, 0, 0, 1, g);
        check("R6 first retard taken", g, 18);
        span(13, 1, 0, 3'd1, 0, 0, 2, g);
        check("R6 request 31 clocks later ignored", g, 32);
        settle();
        span(0, 1, 0, 3'd1, 0, 0, 1, g);
        check("R6 retard taken again", g, 18);
        span(14, 1, 0, 3'd1, 0, 0, 2, g);
        check("R6 request 32 clocks later taken", g, 34);
    endtask

    task automatic t_dither();
        int g;
        settle();
        dither_amp_i = 4'd5;
        track_i = 1'b1;
        span(0, 0, 0, 3'd0, 0, 1, 1, g);
        check("R9 reload while plain has no phase effect", g, 16);
        check("R10 still plain", int'(dither_o), 0);
        span(0, 0, 0, 3'd0, 1, 0, 1, g);
        check("R8 enter retard by 5", g, 21);
        check("R10 dither high when retarded", int'(dither_o), 1);
        span(0, 0, 0, 3'd0, 1, 0, 1, g);
        check("R8 leave retard by 5", g, 11);
        check("R10 dither low when plain", int'(dither_o), 0);
        span(0, 0, 0, 3'd0, 1, 0, 1, g);
        check("R8 enter retard again", g, 21);
        dither_amp_i = 4'd9;
        span(0, 0, 0, 3'd0, 1, 0, 1, g);
        check("R9 old amplitude removed without reload", g, 11);
        span(0, 0, 0, 3'd0, 1, 0, 1, g);
        check("R9 old amplitude kept without reload", g, 21);
        span(0, 0, 0, 3'd0, 0, 1, 1, g);
        check("R9 reload while retarded adds 4", g, 20);
        check("R10 dither stays high over reload", int'(dither_o), 1);
        track_i = 1'b0;
        span(1000, 0, 0, 3'd0, 0, 0, 1, g);
        check("R7 track off removes retard of 9", g, 7);
        check("R7 dither low with track off", int'(dither_o), 0);
        span(0, 0, 0, 3'd0, 1, 0, 1, g);
        check("R7 tick ignored with track off", g, 16);
        check("R7 dither stays low", int'(dither_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nominal();
        t_advance();
        t_retard();
        t_carry();
        t_guard();
        t_dither();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule